// File: doc/BRIEF.md
# Tap Delay Update Controller

This block owns the tap index of a digital output delay line. It keeps a 9-bit active tap count, which drives the delay line, and a pending value that holds a requested tap count until the selected update policy allows it to take effect. The delay line itself is outside the block and is modelled only as the tap index.

A two-bit type input selects how the tap can change. In fixed type the tap never moves after reset. In variable type the tap moves one step at a time on CE. In variable-with-load type a LOAD strobe also writes an absolute value from the `cnt_in` bus. A second two-bit input selects one of three update policies. Under the asynchronous policy a load takes effect at once. Under the synchronous policy a load waits for a transition on the delayed data. Under the manual policy a load needs two strobes: LOAD alone captures the value, and LOAD with CE then commits it. A registered readback port follows the active tap one cycle later. A configuration check raises an error when quarter-period output phase is requested while the tap is not zero. The delay reset input can be set to either polarity by a parameter.

All inputs are plain control pins sampled on the rising clock edge. There is no data stream and no handshake, so the block applies no back-pressure: every strobe present at an edge is acted on at that edge.

Top module: `tap_dly_ctrl`

## Requirements
- R1: While the effective delay reset is active, the next clock edge sets `tap_out` and the pending value to parameter `INIT_TAP`, cancels any pending synchronous commit and any half-finished manual sequence, and sets `cnt_out` to `INIT_TAP`.
- R2: With `dly_type` = 0 (fixed) or 3 (reserved, treated as fixed), `load`, `ce`, `inc`, `dat_edge` and `cnt_in` have no effect on `tap_out`.
- R3: With `dly_type` = 1 (variable), each edge with `ce`=1 and `load`=0 moves `tap_out` up by one when `inc`=1 and down by one when `inc`=0. The count saturates at 511 and at 0. `load` on its own does nothing in this type.
- R4: With `dly_type` = 2 (variable-with-load) and `upd_mode` = 0 (asynchronous) or 3 (reserved, treated as asynchronous), an edge with `load`=1 makes `tap_out` equal to that cycle's `cnt_in`. An edge with `ce`=1 and `load`=0 steps as in R3.
- R5: With `dly_type` = 2 and `upd_mode` = 1 (synchronous), an edge with `load`=1 stores `cnt_in` as pending and leaves `tap_out` unchanged. The first later edge with `dat_edge`=1 commits the pending value to `tap_out`. That commit outranks a same-cycle CE step. A new `load` in the commit cycle stores a fresh pending value. `dat_edge` with nothing pending has no effect. CE without LOAD steps as in R3 when no commit takes place.
- R6: With `dly_type` = 2 and `upd_mode` = 2 (manual), an edge with `load`=1 and `ce`=0 captures `cnt_in` as pending and arms the sequence, and `tap_out` does not change.
- R7: In manual policy, an edge with `load`=1 and `ce`=1 while armed copies the pending value to `tap_out` and disarms. The same strobes while not armed change nothing. CE without LOAD steps as in R3.
- R8: When parameter `RST_INV` = 1, `dly_rst` is active low. When it is 0, `dly_rst` is active high. Apart from that, behaviour is identical.
- R9: `cfg_err` is 1 exactly when `phase90` = 1 and `tap_out` is not zero.
- R10: On every clock edge outside reset, `cnt_out` takes the value `tap_out` held before that edge, so it shows each commit or step one cycle after `tap_out` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dly_rst | input | 1 | Delay reset, polarity set by `RST_INV` |
| dly_type | input | 2 | 0 fixed, 1 variable, 2 variable-with-load, 3 as fixed |
| upd_mode | input | 2 | 0 async, 1 sync, 2 manual, 3 as async |
| load | input | 1 | Load strobe |
| ce | input | 1 | Step / confirm strobe |
| inc | input | 1 | Step direction, 1 = up |
| dat_edge | input | 1 | Delayed data shows a transition this cycle |
| cnt_in | input | 9 | Tap value to load |
| phase90 | input | 1 | Quarter-period output phase requested |
| tap_out | output | 9 | Active tap count to the delay line |
| cnt_out | output | 9 | Registered readback of the active tap |
| cfg_err | output | 1 | Phase setting conflicts with a nonzero tap |

## Verification
The bound checker watches, on every cycle, that a fixed type freezes the tap, that the tap holds in variable type without CE and saturates at the top, that an asynchronous load lands on the bus value, that the tap holds while a synchronous load waits for a data edge, that a manual capture leaves the tap alone, that the readback lags by one cycle, and that no error appears without the phase request. Only the bench scenarios can show the full sequences. These include a capture followed by a commit some cycles later, a confirm with no prior capture, a commit and a new load in the same cycle, reset in the middle of a sequence, and that both reset polarities behave alike. The bench covers them with directed cases and a seeded random run compared against a reference model.

// File: rtl/tap_dly_pkg.sv
package tap_dly_pkg;
  typedef enum logic [1:0] {
    DT_FIXED = 2'd0,
    DT_VAR   = 2'd1,
    DT_VLOAD = 2'd2,
    DT_RSVD  = 2'd3
  } dly_type_e;

  typedef enum logic [1:0] {
    UP_ASYNC  = 2'd0,
    UP_SYNC   = 2'd1,
    UP_MANUAL = 2'd2,
    UP_RSVD   = 2'd3
  } upd_mode_e;
endpackage

// File: rtl/tap_step.sv
module tap_step #(
  parameter int TAP_W = 9
) (
  input  logic [TAP_W-1:0] cur,
  input  logic             inc,
  output logic [TAP_W-1:0] nxt
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] TAP_MIN = '0;
  localparam logic [TAP_W-1:0] ONE     = TAP_W'(1);

  always_comb begin
    nxt = cur;
    if (inc) begin
      if (cur != TAP_MAX) nxt = cur + ONE;
    end else begin
      if (cur != TAP_MIN) nxt = cur - ONE;
    end
  end
endmodule

// File: rtl/tap_commit.sv
module tap_commit
  import tap_dly_pkg::*;
#(
  parameter int TAP_W = 9,
  parameter logic [TAP_W-1:0] INIT_TAP = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  dly_type_e        dtype,
  input  upd_mode_e        umode,
  input  logic             load,
  input  logic             ce,
  input  logic             dat_edge,
  input  logic [TAP_W-1:0] cnt_in,
  output logic             cmt_en,
  output logic [TAP_W-1:0] cmt_val,
  output logic             step_en
);
  logic [TAP_W-1:0] pend_q;
  logic             pv_q, pv_d;
  logic             arm_q, arm_d;
  logic             cap;

  always_comb begin
    cmt_en  = 1'b0;
    cmt_val = pend_q;
    step_en = 1'b0;
    cap     = 1'b0;
    pv_d    = pv_q;
    arm_d   = arm_q;
    case (dtype)
      DT_VAR: step_en = ce & ~load;
      DT_VLOAD: begin
        case (umode)
          UP_SYNC: begin
            if (dat_edge && pv_q) begin
              cmt_en = 1'b1;
              pv_d   = 1'b0;
            end else begin
              step_en = ce & ~load;
            end
            if (load) begin
              cap  = 1'b1;
              pv_d = 1'b1;
            end
          end
          UP_MANUAL: begin
            if (load && !ce) begin
              cap   = 1'b1;
              arm_d = 1'b1;
            end else if (load && ce && arm_q) begin
              cmt_en = 1'b1;
              arm_d  = 1'b0;
            end else begin
              step_en = ce & ~load;
            end
          end
          default: begin
            if (load) begin
              cmt_en  = 1'b1;
              cmt_val = cnt_in;
            end else begin
              step_en = ce;
            end
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= INIT_TAP;
      pv_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (cap) pend_q <= cnt_in;
      pv_q  <= pv_d;
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/tap_dly_ctrl.sv
module tap_dly_ctrl
  import tap_dly_pkg::*;
#(
  parameter int TAP_W = 9,
  parameter logic [TAP_W-1:0] INIT_TAP = '0,
  parameter bit RST_INV = 1'b0
) (
  input  logic             clk,
  input  logic             dly_rst,
  input  logic [1:0]       dly_type,
  input  logic [1:0]       upd_mode,
  input  logic             load,
  input  logic             ce,
  input  logic             inc,
  input  logic             dat_edge,
  input  logic [TAP_W-1:0] cnt_in,
  input  logic             phase90,
  output logic [TAP_W-1:0] tap_out,
  output logic [TAP_W-1:0] cnt_out,
  output logic             cfg_err
);
  logic             rst_eff;
  logic             cmt_en, step_en;
  logic [TAP_W-1:0] cmt_val, step_nxt;
  logic [TAP_W-1:0] tap_q, cnt_q;

  generate
    if (RST_INV) begin : g_rst_low
      assign rst_eff = ~dly_rst;
    end else begin : g_rst_high
      assign rst_eff = dly_rst;
    end
  endgenerate

  tap_commit #(.TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_commit (
    .clk      (clk),
    .rst      (rst_eff),
    .dtype    (dly_type_e'(dly_type)),
    .umode    (upd_mode_e'(upd_mode)),
    .load     (load),
    .ce       (ce),
    .dat_edge (dat_edge),
    .cnt_in   (cnt_in),
    .cmt_en   (cmt_en),
    .cmt_val  (cmt_val),
    .step_en  (step_en)
  );

  tap_step #(.TAP_W(TAP_W)) u_step (
    .cur (tap_q),
    .inc (inc),
    .nxt (step_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      tap_q <= INIT_TAP;
      cnt_q <= INIT_TAP;
    end else begin
      if (cmt_en)       tap_q <= cmt_val;
      else if (step_en) tap_q <= step_nxt;
      cnt_q <= tap_q;
    end
  end

  assign tap_out = tap_q;
  assign cnt_out = cnt_q;
  assign cfg_err = phase90 && (tap_q != '0);
endmodule

// File: rtl/tap_dly_ctrl_chk.sv
module tap_dly_ctrl_chk #(
  parameter int TAP_W = 9,
  parameter bit RST_INV = 1'b0
) (
  input logic             clk,
  input logic             dly_rst,
  input logic [1:0]       dly_type,
  input logic [1:0]       upd_mode,
  input logic             load,
  input logic             ce,
  input logic             inc,
  input logic             dat_edge,
  input logic [TAP_W-1:0] cnt_in,
  input logic             phase90,
  input logic [TAP_W-1:0] tap_out,
  input logic [TAP_W-1:0] cnt_out,
  input logic             cfg_err
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  logic in_rst;
  assign in_rst = RST_INV ? !dly_rst : dly_rst;

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd0 || dly_type == 2'd3) |=> $stable(tap_out)); // R2
  AST_VAR_IDLE: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd1 && !ce) |=> $stable(tap_out)); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd1 && ce && !load && inc && tap_out == TAP_MAX) |=> (tap_out == TAP_MAX)); // R3
  AST_ASYNC_LOAD: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd2 && (upd_mode == 2'd0 || upd_mode == 2'd3) && load) |=> (tap_out == $past(cnt_in))); // R4
  AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd2 && upd_mode == 2'd1 && !dat_edge && !ce) |=> $stable(tap_out)); // R5
  AST_MANUAL_CAPTURE: assert property (@(posedge clk) disable iff (in_rst)
    (dly_type == 2'd2 && upd_mode == 2'd2 && load && !ce) |=> $stable(tap_out)); // R6
  AST_NO_ERR_NO_PHASE: assert property (@(posedge clk) disable iff (in_rst)
    !phase90 |-> !cfg_err); // R9
  AST_READBACK_LAG: assert property (@(posedge clk) disable iff (in_rst)
    1'b1 |=> (cnt_out == $past(tap_out))); // R10
endmodule

bind tap_dly_ctrl tap_dly_ctrl_chk #(.TAP_W(TAP_W), .RST_INV(RST_INV)) u_chk (
  .clk      (clk),
  .dly_rst  (dly_rst),
  .dly_type (dly_type),
  .upd_mode (upd_mode),
  .load     (load),
  .ce       (ce),
  .inc      (inc),
  .dat_edge (dat_edge),
  .cnt_in   (cnt_in),
  .phase90  (phase90),
  .tap_out  (tap_out),
  .cnt_out  (cnt_out),
  .cfg_err  (cfg_err)
);

// File: tb/tap_dly_ctrl_test.sv
module tap_dly_ctrl_test;
  localparam int W = 9;
  localparam logic [W-1:0] INIT = 9'd37;

  logic clk = 1'b0;
  logic dly_rst = 1'b1;
  logic dly_rst_n;
  logic [1:0] dly_type = 2'd0, upd_mode = 2'd0;
  logic load = 0, ce = 0, inc = 0, dat_edge = 0, phase90 = 0;
  logic [W-1:0] cnt_in = '0;
  logic [W-1:0] tap_out, cnt_out, tap_b, cnt_b;
  logic cfg_err, cfg_b;

  int nchk = 0, nfail = 0;
  logic [W-1:0] m_tap, m_pend, m_prev;
  bit m_pv, m_arm;

  always #5 clk = ~clk;
  assign dly_rst_n = ~dly_rst;

  tap_dly_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .RST_INV(1'b0)) uut (
    .clk(clk), .dly_rst(dly_rst), .dly_type(dly_type), .upd_mode(upd_mode),
    .load(load), .ce(ce), .inc(inc), .dat_edge(dat_edge), .cnt_in(cnt_in),
    .phase90(phase90), .tap_out(tap_out), .cnt_out(cnt_out), .cfg_err(cfg_err));

  tap_dly_ctrl #(.TAP_W(W), .INIT_TAP(INIT), .RST_INV(1'b1)) uut_inv (
    .clk(clk), .dly_rst(dly_rst_n), .dly_type(dly_type), .upd_mode(upd_mode),
    .load(load), .ce(ce), .inc(inc), .dat_edge(dat_edge), .cnt_in(cnt_in),
    .phase90(phase90), .tap_out(tap_b), .cnt_out(cnt_b), .cfg_err(cfg_b));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] stepped(logic [W-1:0] c, bit up);
    if (up) return (c == 9'd511) ? c : c + 9'd1;
    return (c == 9'd0) ? c : c - 9'd1;
  endfunction

  // Reference model: update per requirements R1..R7 from the inputs of one edge
  task automatic model_edge();
    logic [W-1:0] nt;
    nt = m_tap;
    m_prev = m_tap;
    if (dly_rst) begin
      m_tap = INIT; m_pend = INIT; m_pv = 0; m_arm = 0; m_prev = INIT;
      return;
    end
    if (dly_type == 2'd1) begin
      if (ce && !load) nt = stepped(m_tap, inc);
    end else if (dly_type == 2'd2) begin
      if (upd_mode == 2'd1) begin
        if (dat_edge && m_pv) begin nt = m_pend; m_pv = 0; end
        else if (ce && !load) nt = stepped(m_tap, inc);
        if (load) begin m_pend = cnt_in; m_pv = 1; end
      end else if (upd_mode == 2'd2) begin
        if (load && !ce) begin m_pend = cnt_in; m_arm = 1; end
        else if (load && ce && m_arm) begin nt = m_pend; m_arm = 0; end
        else if (ce && !load) nt = stepped(m_tap, inc);
      end else begin
        if (load) nt = cnt_in;
        else if (ce) nt = stepped(m_tap, inc);
      end
    end
    m_tap = nt;
  endtask

  function automatic string tag_of();
    if (dly_rst) return "R1";
    if (dly_type == 2'd1) return "R3";
    if (dly_type != 2'd2) return "R2";
    if (upd_mode == 2'd1) return "R5";
    if (upd_mode == 2'd2) return (load && ce) ? "R7" : "R6";
    return "R4";
  endfunction

  // Inputs are already set (driven at negedge); one edge, then check at negedge
  task automatic cycle();
    string t;
    t = tag_of();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(t, tap_out, m_tap);
    chk("R10", cnt_out, m_prev);
    chk("R9", cfg_err, (phase90 && m_tap != 0) ? 1 : 0);
    chk("R8", tap_b, tap_out);
  endtask

  task automatic drive(bit r, int ty, int um, bit ld, bit c, bit up, bit de, int v);
    dly_rst = r; dly_type = 2'(ty); upd_mode = 2'(um); load = ld; ce = c;
    inc = up; dat_edge = de; cnt_in = W'(v);
    cycle();
  endtask

  initial begin
    #1500000;
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_tap = INIT; m_pend = INIT; m_pv = 0; m_arm = 0; m_prev = INIT;
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", tap_out, 37); chk("R1", cnt_out, 37); chk("R8", tap_b, 37);
    // R2: fixed type ignores strobes
    drive(0, 0, 0, 1, 1, 1, 1, 200);
    drive(0, 3, 0, 0, 1, 1, 0, 5);
    chk("R2", tap_out, 37);
    // R4: async load
    drive(0, 2, 0, 1, 0, 0, 0, 300);
    chk("R4", tap_out, 300);
    // R5: sync waits for data edge
    drive(0, 2, 1, 1, 0, 0, 0, 5);
    drive(0, 2, 1, 0, 0, 0, 0, 0);
    drive(0, 2, 1, 0, 0, 0, 0, 0);
    chk("R5", tap_out, 300);
    drive(0, 2, 1, 0, 0, 0, 1, 0);
    chk("R5", tap_out, 5);
    drive(0, 2, 1, 0, 0, 0, 1, 0);
    chk("R5", tap_out, 5);
    // R6/R7: manual two-step
    drive(0, 2, 2, 1, 0, 0, 0, 77);
    chk("R6", tap_out, 5);
    drive(0, 2, 2, 1, 1, 0, 0, 99);
    chk("R7", tap_out, 77);
    drive(0, 2, 2, 1, 1, 0, 0, 99);
    chk("R7", tap_out, 77);
    // R1: reset clears an armed manual sequence
    drive(0, 2, 2, 1, 0, 0, 0, 150);
    drive(1, 2, 2, 0, 0, 0, 0, 0);
    drive(0, 2, 2, 1, 1, 0, 0, 0);
    chk("R1", tap_out, 37);
    // R3: saturation at both ends
    for (int i = 0; i < 480; i++) drive(0, 1, 0, 0, 1, 1, 0, 0);
    chk("R3", tap_out, 511);
    drive(0, 1, 0, 1, 0, 0, 0, 3);
    chk("R3", tap_out, 511);
    phase90 = 1;
    for (int i = 0; i < 515; i++) drive(0, 1, 0, 0, 1, 0, 0, 0);
    chk("R3", tap_out, 0);
    chk("R9", cfg_err, 0);
    drive(0, 1, 0, 0, 1, 1, 0, 0);
    chk("R9", cfg_err, 1);
    phase90 = 0;
    // constrained random run
    for (int i = 0; i < 20000; i++) begin
      drive(($urandom % 64) == 0, $urandom % 4, $urandom % 4,
            ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            ($urandom % 4) == 0, $urandom % 512);
      phase90 = $urandom % 2;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule